// File: doc/BRIEF.md
# Six-Channel Phase-Shiftable PWM Generator

This block drives six pulse-width modulated outputs from one shared 15-bit counter. The counter runs in one of two modes. In the edge-aligned mode it ramps from zero up to a programmed period value and then restarts. In the center-aligned mode it climbs to the period value and then falls back toward zero, so every pulse is symmetric about the peak. Each channel has its own duty value and its own phase offset. The phase offset shifts that channel's pulse in time against the shared counter, which gives phase-staggered waveforms.

Software writes the period, the counting mode, and the per-channel duty and phase values through a single-cycle write port. All written values first go into shadow registers. They become active together only at the start of a new counter cycle, so a half-written set never reaches the outputs. A one-clock reload pulse marks each cycle start.

Top module: `pwm6_gen`

## Requirements
- R1: While reset is held and directly after it, all six outputs and the reload pulse are low. The active period is the parameter PER_RST and the counting mode is edge-aligned. Every duty and phase value is zero.
- R2: In edge-aligned mode (mode bit 0) with active period P, the counter position runs 0,1,...,P and then returns to 0, so one cycle lasts P+1 clocks. For a duty D with 0 < D < P, the output is high exactly while the shifted position is below D.
- R3: In center-aligned mode (mode bit 1) with P ≥ 1, the count runs 0,1,...,P,P-1,...,1 and one cycle lasts 2P clocks. The output is high while the count at the shifted position is below D, which gives 2D-1 high clocks per cycle that are symmetric about position 0.
- R4: Channel i compares at the shifted position (position + phase_i) modulo the cycle length. The position is the clock index within the cycle. The phase must be less than the cycle length.
- R5: A duty of 0 holds the output low. A nonzero duty that is at or above the active period holds the output high. Duty 0 takes precedence.
- R6: Values written to the period, the mode, a duty or a phase register do not affect the outputs until the next cycle start. At that start they all take effect together. Register addresses: 0 = period, 1 = mode (data bit 0), 2..7 = duty of channels 0..5, 8..13 = phase of channels 0..5.
- R7: reload_pulse is high for exactly one clock, in the first clock of every cycle, and low otherwise.
- R8: With an active period of 0, every clock is a cycle start, so reload_pulse stays high. Outputs then follow R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | 15 | Register write data |
| pwm_out | output | 6 | PWM outputs, bit i is channel i |
| reload_pulse | output | 1 | High in the first clock of each counter cycle |

## Verification
The outputs are first tried in edge-aligned mode with zero phase. The duty values cover zero, small, equal-to-period and above-period, so the forced-low and forced-high cases can be told apart from normal comparison. Nonzero phases are then added, which separates a correct modulo shift from an unshifted compare. Center-aligned mode is run with and without phase. Its cycle length and its 2D-1 symmetric high count distinguish it from a plain ramp. Writes made in the middle of a cycle, and periods of 0 and 1, confirm the shadow loading and the degenerate cycle lengths.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
    localparam int ADDR_W      = 4;
    localparam int ADDR_PERIOD = 0;
    localparam int ADDR_MODE   = 1;
    localparam int ADDR_DUTY0  = 2;
    localparam int ADDR_PHASE0 = 8;

    typedef enum logic {
        CNT_EDGE   = 1'b0,
        CNT_CENTER = 1'b1
    } cnt_mode_e;
endpackage

// File: rtl/pwm6_regs.sv
module pwm6_regs
    import pwm6_pkg::*;
#(
    parameter int          NCH     = 6,
    parameter int          CW      = 15,
    parameter logic [14:0] PER_RST = 15'd100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CW-1:0]           wr_data,
    input  logic                    load,
    output logic [CW-1:0]           per_o,
    output cnt_mode_e               mode_o,
    output logic [NCH-1:0][CW-1:0]  duty_o,
    output logic [NCH-1:0][CW-1:0]  phase_o
);
    typedef struct packed {
        logic [CW-1:0]          sh_per;
        logic [CW-1:0]          act_per;
        cnt_mode_e              sh_mode;
        cnt_mode_e              act_mode;
        logic [NCH-1:0][CW-1:0] sh_duty;
        logic [NCH-1:0][CW-1:0] act_duty;
        logic [NCH-1:0][CW-1:0] sh_ph;
        logic [NCH-1:0][CW-1:0] act_ph;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (load) begin
            regs_d.act_per  = regs_q.sh_per;
            regs_d.act_mode = regs_q.sh_mode;
            regs_d.act_duty = regs_q.sh_duty;
            regs_d.act_ph   = regs_q.sh_ph;
        end
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_PERIOD)) regs_d.sh_per = wr_data;
            if (wr_addr == ADDR_W'(ADDR_MODE))   regs_d.sh_mode = cnt_mode_e'(wr_data[0]);
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == ADDR_W'(ADDR_DUTY0 + i))  regs_d.sh_duty[i] = wr_data;
                if (wr_addr == ADDR_W'(ADDR_PHASE0 + i)) regs_d.sh_ph[i]   = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.sh_per   <= CW'(PER_RST);
            regs_q.act_per  <= CW'(PER_RST);
            regs_q.sh_mode  <= CNT_EDGE;
            regs_q.act_mode <= CNT_EDGE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign per_o   = regs_q.act_per;
    assign mode_o  = regs_q.act_mode;
    assign duty_o  = regs_q.act_duty;
    assign phase_o = regs_q.act_ph;

    // R6: the active set only moves on a cycle-start load
    p_active_only_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.act_per != $past(regs_q.act_per) || regs_q.act_duty != $past(regs_q.act_duty))
        |-> $past(load));
endmodule

// File: rtl/pwm6_counter.sv
module pwm6_counter
    import pwm6_pkg::*;
#(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] per,
    input  cnt_mode_e     mode,
    output logic [CW-1:0] cnt_o,
    output logic          down_o,
    output logic          boundary_o,
    output logic          reload_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
        logic          reload;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic bnd;

    always_comb begin
        cnt_d        = cnt_q;
        cnt_d.reload = 1'b0;
        bnd          = 1'b0;
        if (mode == CNT_EDGE) begin
            if (cnt_q.cnt >= per) bnd = 1'b1;
            else                  cnt_d.cnt = cnt_q.cnt + 1'b1;
        end else if (!cnt_q.down) begin
            if (cnt_q.cnt >= per) begin
                if (per <= CW'(1)) bnd = 1'b1;
                else begin
                    cnt_d.down = 1'b1;
                    cnt_d.cnt  = per - 1'b1;
                end
            end else begin
                cnt_d.cnt = cnt_q.cnt + 1'b1;
            end
        end else begin
            if (cnt_q.cnt <= CW'(1)) bnd = 1'b1;
            else                     cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
        if (bnd) begin
            cnt_d.cnt    = '0;
            cnt_d.down   = 1'b0;
            cnt_d.reload = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o      = cnt_q.cnt;
    assign down_o     = cnt_q.down;
    assign boundary_o = bnd;
    assign reload_o   = cnt_q.reload;

    // R7: a reload clock is always the zero point of a fresh upward cycle
    p_reload_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.reload |-> (cnt_q.cnt == '0 && !cnt_q.down));
    // R2: the count never leaves the active period
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.cnt <= per);
    // R3: counting down only happens in center-aligned mode
    p_down_only_center_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.down |-> (mode == CNT_CENTER && cnt_q.cnt < per));
endmodule

// File: rtl/pwm6_chan.sv
module pwm6_chan
    import pwm6_pkg::*;
#(
    parameter int CW = 15
) (
    input  logic [CW-1:0] per,
    input  cnt_mode_e     mode,
    input  logic [CW-1:0] cnt,
    input  logic          down,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] phase,
    output logic          out
);
    localparam int W2 = CW + 2;

    logic [W2-1:0] p2, len, pos, shifted, fold;

    always_comb begin
        p2  = W2'(per);
        if (per == '0)               len = W2'(1);
        else if (mode == CNT_CENTER) len = p2 << 1;
        else                         len = p2 + W2'(1);
        pos     = down ? (p2 << 1) - W2'(cnt) : W2'(cnt);
        shifted = pos + W2'(phase);
        if (shifted >= len) shifted = shifted - len;
        fold = (mode == CNT_CENTER && shifted > p2) ? (p2 << 1) - shifted : shifted;
        if (duty == '0)           out = 1'b0;
        else if (duty >= per)     out = 1'b1;
        else                      out = (fold < W2'(duty));
    end
endmodule

// File: rtl/pwm6_gen.sv
module pwm6_gen
    import pwm6_pkg::*;
#(
    parameter int          NCH     = 6,
    parameter int          CW      = 15,
    parameter logic [14:0] PER_RST = 15'd100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [3:0]     wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NCH-1:0] pwm_out,
    output logic           reload_pulse
);
    logic [CW-1:0]          per;
    cnt_mode_e              mode;
    logic [NCH-1:0][CW-1:0] duty, phase;
    logic [CW-1:0]          cnt;
    logic                   down, boundary;

    pwm6_regs #(.NCH(NCH), .CW(CW), .PER_RST(PER_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(boundary), .per_o(per), .mode_o(mode),
        .duty_o(duty), .phase_o(phase)
    );

    pwm6_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .per(per), .mode(mode), .cnt_o(cnt),
        .down_o(down), .boundary_o(boundary), .reload_o(reload_pulse)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm6_chan #(.CW(CW)) u_ch (
            .per(per), .mode(mode), .cnt(cnt), .down(down),
            .duty(duty[g]), .phase(phase[g]), .out(pwm_out[g])
        );

        // R5: zero duty never lets the pin rise
        p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (duty[g] == '0) |-> !pwm_out[g]);
        // R5: full duty keeps the pin high for the whole cycle
        p_full_duty_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (duty[g] != '0 && duty[g] >= per) |-> pwm_out[g]);
    end
endmodule

// File: tb/test_pwm6_gen.sv
module test_pwm6_gen;
    localparam int          NCH  = 6;
    localparam int          CW   = 15;
    localparam logic [14:0] PER0 = 15'd100;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [CW-1:0]  wr_data = '0;
    logic [NCH-1:0] pwm_out;
    logic           reload_pulse;

    pwm6_gen #(.NCH(NCH), .CW(CW), .PER_RST(PER0)) i_pwm6_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .reload_pulse(reload_pulse)
    );

    always #4 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    sb_on = 1'b0;

    // reference model state
    int s_per, s_mode, a_per, a_mode, m_pos;
    int s_duty[NCH], s_ph[NCH], a_duty[NCH], a_ph[NCH];
    bit m_rel;
    logic [NCH:0] exp_q[$];

    function automatic int cyc_len(int p, int m);
        if (p == 0) return 1;
        return (m != 0) ? 2 * p : p + 1;
    endfunction

    function automatic bit ref_out(int i);
        int s, c;
        if (a_duty[i] == 0) return 1'b0;
        if (a_duty[i] >= a_per) return 1'b1;
        s = (m_pos + a_ph[i]) % cyc_len(a_per, a_mode);
        c = (a_mode != 0 && s > a_per) ? 2 * a_per - s : s;
        return c < a_duty[i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            s_per = PER0; a_per = PER0; s_mode = 0; a_mode = 0; m_pos = 0; m_rel = 0;
            for (int i = 0; i < NCH; i++) begin
                s_duty[i] = 0; s_ph[i] = 0; a_duty[i] = 0; a_ph[i] = 0;
            end
        end else begin
            if (m_pos + 1 >= cyc_len(a_per, a_mode)) begin
                m_pos = 0; m_rel = 1;
                a_per = s_per; a_mode = s_mode;
                for (int i = 0; i < NCH; i++) begin
                    a_duty[i] = s_duty[i]; a_ph[i] = s_ph[i];
                end
            end else begin
                m_pos = m_pos + 1; m_rel = 0;
            end
            if (wr_en) begin
                if (wr_addr == 0) s_per = wr_data;
                else if (wr_addr == 1) s_mode = wr_data[0];
                else if (wr_addr >= 2 && wr_addr < 8) s_duty[wr_addr - 2] = wr_data;
                else if (wr_addr >= 8 && wr_addr < 14) s_ph[wr_addr - 8] = wr_data;
            end
        end
    end

    // driver side: push the expected item for this cycle
    always @(negedge clk) begin
        if (sb_on) begin
            logic [NCH:0] e;
            e[NCH] = m_rel;
            for (int i = 0; i < NCH; i++) e[i] = ref_out(i);
            exp_q.push_back(e);
        end
    end

    // monitor side: pop and compare
    always @(negedge clk) begin
        #1;
        if (sb_on && exp_q.size() > 0) begin
            logic [NCH:0] e;
            e = exp_q.pop_front();
            n_vec++;
            if ({reload_pulse, pwm_out} !== e) begin
                n_bad++;
                $display("FAIL %s: {reload,pwm}=%b expected %b at %0t", cur_req,
                         {reload_pulse, pwm_out}, e, $time);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk); #2;
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
    endtask

    task automatic wait_reload();
        int guard = 0;
        step();
        while (!reload_pulse && guard < 1000) begin
            step(); guard++;
        end
    endtask

    task automatic spacing(output int n);
        wait_reload();
        n = 1;
        step();
        while (!reload_pulse && n < 1000) begin
            step(); n++;
        end
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run did not end, got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n, hi, lo0, hi3;
        repeat (3) step();
        check("R1", int'(pwm_out), 0);
        check("R1", int'(reload_pulse), 0);
        @(negedge clk); rst_n = 1'b1; #2;
        check("R1", int'(pwm_out), 0);
        check("R1", int'(reload_pulse), 0);
        sb_on = 1'b1;

        // R6: program edge mode while the reset period is still running
        cur_req = "R6";
        wr(0, 9); wr(1, 0);
        wr(2, 0); wr(3, 3); wr(4, 5); wr(5, 9); wr(6, 12); wr(7, 7);
        check("R6", int'(pwm_out), 0);
        wait_reload();
        check("R6", int'(pwm_out[3]), 1);

        // R2: edge cycle length and compare
        cur_req = "R2";
        spacing(n);
        check("R2", n, 10);
        run(25);

        // R5: zero duty low, duty >= period high, over a full cycle
        cur_req = "R5";
        lo0 = 0; hi3 = 1;
        for (int k = 0; k < 10; k++) begin
            step();
            lo0 = lo0 | int'(pwm_out[0]);
            hi3 = hi3 & int'(pwm_out[3]) & int'(pwm_out[4]);
        end
        check("R5", lo0, 0);
        check("R5", hi3, 1);

        // R4: edge mode with phase offsets
        cur_req = "R4";
        wr(8, 0); wr(9, 2); wr(10, 4); wr(11, 6); wr(12, 8); wr(13, 9);
        wait_reload();
        wait_reload();
        step();
        check("R4", int'(pwm_out[1]), 0);
        run(30);

        // R3: center mode, no phase
        cur_req = "R3";
        wr(0, 8); wr(1, 1);
        wr(2, 0); wr(3, 2); wr(4, 4); wr(5, 8); wr(6, 3); wr(7, 6);
        for (int i = 8; i < 14; i++) wr(i, 0);
        wait_reload();
        spacing(n);
        check("R3", n, 16);
        hi = 0;
        for (int k = 0; k < 16; k++) begin
            hi += int'(pwm_out[2]);
            step();
        end
        check("R3", hi, 7);
        run(20);

        // R4: center mode with phase
        cur_req = "R4";
        wr(8, 0); wr(9, 3); wr(10, 5); wr(11, 15); wr(12, 7); wr(13, 12);
        wait_reload();
        run(40);

        // R8: zero period, every clock is a cycle start
        cur_req = "R8";
        wr(0, 0); wr(1, 0);
        for (int i = 8; i < 14; i++) wr(i, 0);
        wait_reload();
        step();
        hi = 0;
        for (int k = 0; k < 5; k++) begin
            hi += int'(reload_pulse);
            step();
        end
        check("R8", hi, 5);
        check("R8", int'(pwm_out[4]), 1);
        check("R8", int'(pwm_out[0]), 0);

        // R7: period 1 edge mode, one pulse every two clocks
        cur_req = "R7";
        wr(0, 1); wr(3, 1);
        run(4);
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            hi += int'(reload_pulse);
            step();
        end
        check("R7", hi, 5);
        run(10);

        sb_on = 1'b0;
        step();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule